// File: doc/BRIEF.md
# Prescaled Timer/Counter with Match and Capture Channels

The block is a 32-bit timer/counter with a 32-bit prescaler in front of it. The prescaler advances on every enabled tick. The count source is chosen in software. It is either every cycle of the internal clock, or the edges of one chosen capture input, which then acts as an external event clock. All external pins pass through a two-flop synchronizer. Edges are found in the internal clock domain, so external events can be counted reliably only up to half the internal clock rate. That means each pin level must be held for at least two clock cycles.

Four match registers are compared with the counter. On a match the block can set a sticky interrupt flag, return the counter to zero, or stop it. Four capture channels take a snapshot of the counter on an enabled rising and/or falling edge of their pin, and can also set a flag. When one capture pin is used as the event clock, it stops capturing. The other three capture pins keep working as capture channels. Software reaches the block through a plain register port: writes are synchronous and reads are combinational.

Top module: `capmatch_timer`

## Requirements
- R1: After reset every register reads zero (control at address 0, prescale limit 1, prescale count 2, timer count 3, match control 4, capture control 5, flags 6, match values 8..11, capture values 12..15) and `irq` is low.
- R2: With control bit0 (run) set, source field bits[3:2]=0 (internal) and prescale limit P, the prescale count goes 0..P and then wraps to 0. On each wrap the timer count increases by one, so the timer count advances once every P+1 clocks. When run is 0 neither count changes.
- R3: While control bit1 (clear) is 1, both the prescale count and the timer count are held at zero.
- R4: With source field 1 (rising), 2 (falling) or 3 (both), a tick happens only on the chosen edge of capture pin number control bits[5:4], seen 3 clocks after the pin changes. Internal clock cycles then give no ticks.
- R5: A match event on channel i happens when the prescaler wraps while the timer count equals match value i. If match control bit 3i (interrupt) is set, the event sets flag bit i, and without reset or stop the count goes on to value+1.
- R6: If match control bit 3i+1 (reset) is set, a match event loads the timer count with zero. When bits 3i+1 and 3i+2 are both set, reset takes effect and the run bit stays 1.
- R7: If only match control bit 3i+2 (stop) is set, a match event holds the timer count at the match value and clears control bit0.
- R8: Capture channel i loads capture register i with the timer count of the cycle in which an enabled edge is found. Capture control bit 3i enables rising edges and bit 3i+1 enables falling edges.
- R9: The capture flag bit 4+i is set on a capture only when capture control bit 3i+2 is set. The capture register loads either way.
- R10: In an external source mode the selected pin never captures, while the other capture pins keep capturing.
- R11: Flags are sticky. Writing a 1 to a flag bit at address 6 clears that bit and writing a 0 leaves it. `irq` is the OR of all flag bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | internal clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_addr | input | 4 | register address |
| reg_we | input | 1 | write strobe |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for reg_addr, combinational |
| cap_pin | input | 4 | capture / event pins, asynchronous |
| irq | output | 1 | OR of all sticky flags |

## Verification
A wrong prescale count or a missed wrap shows up at the timer-count address after a single prescale period, and the error grows with every period after that. A match that resets, stops or flags on the wrong count shows within one tick of the match value: the count falls back, freezes or runs on, and the run bit or the flag bit is visible at the next read. A synchronizer or source-select fault shows as a missing or extra tick three clocks after a pin edge. A capture fault shows in the capture registers and flag bits as soon as the edge has been synchronized.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int AW = 4;

  localparam logic [AW-1:0] A_CTL  = 4'd0;
  localparam logic [AW-1:0] A_PRE  = 4'd1;
  localparam logic [AW-1:0] A_PCNT = 4'd2;
  localparam logic [AW-1:0] A_TCNT = 4'd3;
  localparam logic [AW-1:0] A_MCTL = 4'd4;
  localparam logic [AW-1:0] A_CCTL = 4'd5;
  localparam logic [AW-1:0] A_FLG  = 4'd6;
  localparam int            A_MR   = 8;
  localparam int            A_CAP  = 12;

  // per-channel control bit offsets (3 bits per channel)
  localparam int MC_IRQ  = 0;
  localparam int MC_RST  = 1;
  localparam int MC_STOP = 2;
  localparam int CC_RISE = 0;
  localparam int CC_FALL = 1;
  localparam int CC_IRQ  = 2;

  typedef enum logic [1:0] {
    SRC_INT  = 2'd0,
    SRC_RISE = 2'd1,
    SRC_FALL = 2'd2,
    SRC_BOTH = 2'd3
  } src_e;
endpackage

// File: rtl/cm_edge.sv
module cm_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic [2:0] sh_q;  // [0],[1] synchronizer, [2] previous level
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[1:0], pin[i]};
    end
    assign rise[i] =  sh_q[1] & ~sh_q[2];
    assign fall[i] = ~sh_q[1] &  sh_q[2];
  end
endmodule

// File: rtl/cm_count.sv
module cm_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] pr,
  input  logic         do_reset,
  input  logic         do_stop,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] tc_q,
  output logic         tc_inc
);
  // wrap at or past the limit, so a lowered limit cannot strand the count
  function automatic logic presc_due(input logic [W-1:0] pc, input logic [W-1:0] lim);
    return pc >= lim;
  endfunction

  function automatic logic [W-1:0] tc_next(input logic [W-1:0] tc,
                                           input logic rst, input logic stp);
    if (rst)      return '0;
    else if (stp) return tc;
    else          return tc + 1'b1;
  endfunction

  assign tc_inc = tick && presc_due(pc_q, pr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      tc_q <= '0;
    end else if (clr) begin
      pc_q <= '0;
      tc_q <= '0;
    end else if (tick) begin
      if (tc_inc) begin
        pc_q <= '0;
        tc_q <= tc_next(tc_q, do_reset, do_stop);
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> ($stable(tc_q) && $stable(pc_q))); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tc_q == '0 && pc_q == '0)); // R3
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_inc && do_reset && !clr) |=> (tc_q == '0)); // R6
endmodule

// File: rtl/cm_match.sv
module cm_match #(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic [W-1:0]        tc,
  input  logic                tc_inc,
  input  logic [N-1:0][W-1:0] mr,
  input  logic [3*N-1:0]      mctl,
  output logic [N-1:0]        irq_set,
  output logic                do_reset,
  output logic                do_stop
);
  import cm_pkg::*;

  logic [N-1:0] hit, want_rst, want_stop;

  for (genvar i = 0; i < N; i++) begin : g_m
    assign hit[i]       = tc_inc && (tc == mr[i]);
    assign irq_set[i]   = hit[i] && mctl[3*i+MC_IRQ];
    assign want_rst[i]  = hit[i] && mctl[3*i+MC_RST];
    assign want_stop[i] = hit[i] && mctl[3*i+MC_STOP];
  end

  assign do_reset = |want_rst;
  assign do_stop  = |want_stop;
endmodule

// File: rtl/cm_capture.sv
module cm_capture #(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        rise,
  input  logic [N-1:0]        fall,
  input  logic [3*N-1:0]      cctl,
  input  logic [N-1:0]        excl,
  input  logic [W-1:0]        tc,
  output logic [N-1:0][W-1:0] cap_q,
  output logic [N-1:0]        irq_set
);
  import cm_pkg::*;

  logic [N-1:0] cap_evt;

  for (genvar i = 0; i < N; i++) begin : g_c
    assign cap_evt[i] = !excl[i] &&
                        ((rise[i] && cctl[3*i+CC_RISE]) || (fall[i] && cctl[3*i+CC_FALL]));
    assign irq_set[i] = cap_evt[i] && cctl[3*i+CC_IRQ];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cap_q[i] <= '0;
      else if (cap_evt[i]) cap_q[i] <= tc;
    end

    AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[i] |=> (cap_q[i] == $past(tc))); // R8
  end
endmodule

// File: rtl/capmatch_timer.sv
module capmatch_timer #(
  parameter int W      = 32,
  parameter int NMATCH = 4,
  parameter int NCAP   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [cm_pkg::AW-1:0] reg_addr,
  input  logic                  reg_we,
  input  logic [W-1:0]          reg_wdata,
  output logic [W-1:0]          reg_rdata,
  input  logic [NCAP-1:0]       cap_pin,
  output logic                  irq
);
  import cm_pkg::*;

  localparam int SELW = (NCAP > 1) ? $clog2(NCAP) : 1;
  localparam int NF   = NMATCH + NCAP;

  // control state
  logic            run_q, clr_q;
  src_e            src_q;
  logic [SELW-1:0] sel_q;
  logic [W-1:0]    pr_q;
  logic [3*NMATCH-1:0] mctl_q;
  logic [3*NCAP-1:0]   cctl_q;
  logic [NMATCH-1:0][W-1:0] mr_q;
  logic [NF-1:0]   flg_q;

  // named internal events
  logic wr_ctl, wr_pre, wr_mctl, wr_cctl, wr_flg;
  logic [NCAP-1:0] rise, fall, excl;
  logic evt_edge, tick, tc_inc, do_reset, do_stop;
  logic [W-1:0] pc, tc;
  logic [NCAP-1:0][W-1:0] cap;
  logic [NMATCH-1:0] m_set;
  logic [NCAP-1:0]   c_set;
  logic [NF-1:0]     f_set;

  assign wr_ctl  = reg_we && reg_addr == A_CTL;
  assign wr_pre  = reg_we && reg_addr == A_PRE;
  assign wr_mctl = reg_we && reg_addr == A_MCTL;
  assign wr_cctl = reg_we && reg_addr == A_CCTL;
  assign wr_flg  = reg_we && reg_addr == A_FLG;

  cm_edge #(.N(NCAP)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise(rise), .fall(fall)
  );

  always_comb begin
    unique case (src_q)
      SRC_RISE: evt_edge = rise[sel_q];
      SRC_FALL: evt_edge = fall[sel_q];
      SRC_BOTH: evt_edge = rise[sel_q] | fall[sel_q];
      default:  evt_edge = 1'b1;
    endcase
  end

  assign tick = run_q && !clr_q && evt_edge;

  for (genvar i = 0; i < NCAP; i++) begin : g_excl
    assign excl[i] = (src_q != SRC_INT) && (sel_q == SELW'(i));
  end

  cm_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(clr_q), .tick(tick), .pr(pr_q),
    .do_reset(do_reset), .do_stop(do_stop),
    .pc_q(pc), .tc_q(tc), .tc_inc(tc_inc)
  );

  cm_match #(.W(W), .N(NMATCH)) u_match (
    .tc(tc), .tc_inc(tc_inc), .mr(mr_q), .mctl(mctl_q),
    .irq_set(m_set), .do_reset(do_reset), .do_stop(do_stop)
  );

  cm_capture #(.W(W), .N(NCAP)) u_cap (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .cctl(cctl_q),
    .excl(excl), .tc(tc), .cap_q(cap), .irq_set(c_set)
  );

  assign f_set = {c_set, m_set};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      clr_q  <= 1'b0;
      src_q  <= SRC_INT;
      sel_q  <= '0;
      pr_q   <= '0;
      mctl_q <= '0;
      cctl_q <= '0;
      flg_q  <= '0;
    end else begin
      if (wr_ctl) begin
        run_q <= reg_wdata[0];
        clr_q <= reg_wdata[1];
        src_q <= src_e'(reg_wdata[3:2]);
        sel_q <= reg_wdata[4 +: SELW];
      end else if (tc_inc && do_stop && !do_reset) begin
        run_q <= 1'b0;
      end
      if (wr_pre)  pr_q   <= reg_wdata;
      if (wr_mctl) mctl_q <= reg_wdata[3*NMATCH-1:0];
      if (wr_cctl) cctl_q <= reg_wdata[3*NCAP-1:0];
      flg_q <= (flg_q & ~(wr_flg ? reg_wdata[NF-1:0] : '0)) | f_set;
    end
  end

  for (genvar i = 0; i < NMATCH; i++) begin : g_mr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mr_q[i] <= '0;
      else if (reg_we && reg_addr == AW'(A_MR + i)) mr_q[i] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTL:   reg_rdata = W'({sel_q, src_q, clr_q, run_q});
      A_PRE:   reg_rdata = pr_q;
      A_PCNT:  reg_rdata = pc;
      A_TCNT:  reg_rdata = tc;
      A_MCTL:  reg_rdata = W'(mctl_q);
      A_CCTL:  reg_rdata = W'(cctl_q);
      A_FLG:   reg_rdata = W'(flg_q);
      default: reg_rdata = '0;
    endcase
    for (int i = 0; i < NMATCH; i++)
      if (reg_addr == AW'(A_MR + i)) reg_rdata = mr_q[i];
    for (int i = 0; i < NCAP; i++)
      if (reg_addr == AW'(A_CAP + i)) reg_rdata = cap[i];
  end

  assign irq = |flg_q;

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_inc && do_stop && !do_reset && !wr_ctl && !clr_q) |=>
      (!run_q && tc == $past(tc))); // R7
  for (genvar k = 0; k < NF; k++) begin : g_fa
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flg_q[k]) |-> $past(f_set[k])); // R11
  end
endmodule

// File: tb/capmatch_timer_tb.sv
`timescale 1ns/1ps
module capmatch_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pins = '0;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  capmatch_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata), .cap_pin(pins), .irq(irq)
  );

  // prescale limit, ticks, expected timer count, expected prescale count
  localparam int VEC [0:4][0:3] = '{
    '{0, 5, 5, 0}, '{1, 7, 3, 1}, '{3, 10, 2, 2}, '{4, 4, 0, 4}, '{2, 9, 3, 0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input int idx);
    pins[idx] = 1'b1;
    repeat (3) @(negedge clk);
    pins[idx] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v);  chk("R1 ctrl", v, 0);
    rd(4'd3, v);  chk("R1 tcnt", v, 0);
    rd(4'd6, v);  chk("R1 flags", v, 0);
    rd(4'd12, v); chk("R1 cap0", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 table of prescale limits and tick counts
    for (int n = 0; n < 5; n++) begin
      wr(4'd0, 32'h2);
      wr(4'd1, VEC[n][0]);
      wr(4'd0, 32'h1);
      repeat (VEC[n][1] - 1) @(negedge clk);
      wr(4'd0, 32'h0);
      rd(4'd3, v); chk("R2 tcnt", v, VEC[n][2]);
      rd(4'd2, v); chk("R2 pcnt", v, VEC[n][3]);
    end

    // R2 hold while stopped
    rd(4'd3, v);
    repeat (5) @(negedge clk);
    rd(4'd3, v2); chk("R2 hold", v2, v);

    // R3 clear overrides run
    wr(4'd0, 32'h3);
    repeat (5) @(negedge clk);
    rd(4'd3, v); chk("R3 tcnt", v, 0);
    rd(4'd2, v); chk("R3 pcnt", v, 0);

    // R5 match interrupt, counting continues
    wr(4'd1, 0);
    wr(4'd8, 3);
    wr(4'd4, 32'h1);
    wr(4'd6, 32'hFF);
    wr(4'd0, 32'h1);
    repeat (6) @(negedge clk);
    rd(4'd3, v); chk("R5 tcnt runs on", v, 6);
    wr(4'd0, 32'h0);
    rd(4'd6, v); chk("R5 flag0", v, 32'h1);
    chk("R11 irq high", {31'd0, irq}, 1);
    wr(4'd6, 32'h0);
    rd(4'd6, v); chk("R11 write zero keeps", v, 32'h1);
    wr(4'd6, 32'h1);
    rd(4'd6, v); chk("R11 w1c", v, 0);
    chk("R11 irq low", {31'd0, irq}, 0);

    // R6 reset plus stop on channel 1: reset wins
    wr(4'd0, 32'h2);
    wr(4'd9, 2);
    wr(4'd4, 32'h30);
    wr(4'd0, 32'h1);
    repeat (7) @(negedge clk);
    rd(4'd3, v); chk("R6 tcnt", v, 1);
    rd(4'd0, v); chk("R6 run kept", v & 32'h1, 1);
    wr(4'd0, 32'h0);

    // R7 stop on channel 2
    wr(4'd0, 32'h2);
    wr(4'd10, 4);
    wr(4'd4, 32'h100);
    wr(4'd0, 32'h1);
    repeat (10) @(negedge clk);
    rd(4'd3, v); chk("R7 tcnt held", v, 4);
    rd(4'd0, v); chk("R7 run cleared", v & 32'h1, 0);

    // R4 external rising edges on pin 1, R10 and R9 captures
    wr(4'd0, 32'h2);
    wr(4'd4, 32'h0);
    wr(4'd1, 0);
    wr(4'd5, 32'h2D);
    wr(4'd6, 32'hFF);
    wr(4'd0, 32'd21);
    repeat (10) @(negedge clk);
    rd(4'd3, v); chk("R4 no internal ticks", v, 0);
    for (int p = 0; p < 5; p++) pulse(1);
    rd(4'd3, v); chk("R4 event count", v, 5);
    pulse(0);
    rd(4'd12, v); chk("R10 other pin captures", v, 5);
    rd(4'd13, v); chk("R10 selected pin no capture", v, 0);
    rd(4'd6, v);  chk("R9 capture flag", v, 32'h10);
    wr(4'd0, 32'h0);

    // R8 falling-only capture on channel 2, no flag (R9)
    wr(4'd0, 32'h2);
    wr(4'd6, 32'hFF);
    wr(4'd5, 32'h80);
    wr(4'd0, 32'h1);
    repeat (6) @(negedge clk);
    wr(4'd0, 32'h0);
    rd(4'd3, v); chk("R2 stopped count", v, 7);
    pins[2] = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd14, v); chk("R8 rise disabled", v, 0);
    pins[2] = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd14, v); chk("R8 fall capture", v, 7);
    rd(4'd6, v);  chk("R9 no flag", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule